// File: doc/BRIEF.md
# Replicated Digit-Serial Averager with Parallel Throughput

This block accepts four unsigned operands in parallel and returns their average, rounded down, at a fixed rate of one operation per `PT` clock cycles. The arithmetic is done by a small digit-serial adder that handles `SDW` bits per cycle, so a single copy would need several cycles per operation. To hold the requested rate, the block keeps several identical copies of the serial core. It hands each operand set to the next copy in rotation and lets the copies overlap in time.

Time after reset is divided into windows of `PT` cycles. The first cycle of each window is its capture cycle. If `in_valid` is high in that cycle, the four operands are loaded into the shift registers of the copy that owns the window. They are then fed to that copy's adder one digit per cycle, least significant digit first. The registered sum digits are gathered back into a parallel word. When a copy finishes, its word is selected, a fixed bit slice is taken from it, and the slice is registered to the output together with a one-cycle valid pulse. The slice drops the two low bits of the sum, which divides the sum by four.

Top module: `avg_tput_wrap`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0 and `out_avg` is 0.
- R2: Windows of `PT` cycles start in the first cycle after reset is released. `in_valid` and `in_ops` are sampled only in the first cycle of each window. Their values in the other cycles of a window have no effect on any result.
- R3: `out_avg` equals bits 9 down to 2 of the 10-bit sum of the four operands, which is floor((a+b+c+d)/4). All operands at 255 give 255, and a sum of 3 gives 0.
- R4: With the default parameters, `out_valid` is high for exactly one cycle, 8 cycles after the capture cycle of its operation (digits + 3).
- R5: Each captured operation produces exactly one result, and results leave in capture order. Valid operations in back-to-back windows produce one result every `PT` cycles.
- R6: A window whose capture cycle sees `in_valid` low produces no result.
- R7: The number of copies is OD/PT. OD is the digit count plus one, raised to the next multiple of `PT`. A copy is loaded only when it has no digits left to feed.
- R8: Ownership of windows rotates through the copies every window, whether or not the window carries a valid operation.
- R9: Between pulses, `out_avg` holds the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set present, sampled in the window's first cycle |
| in_ops | input | NUM_IN*DATA_W | Four packed unsigned operands, operand 0 in the low byte |
| out_valid | output | 1 | One-cycle pulse marking a new average |
| out_avg | output | SEL_HI-SEL_LO+1 | Selected slice of the sum (the average) |

## Verification
Two events can fall in the same cycle. In one, a copy collects the last digit of its result. In the other, the same copy is reloaded with the next operand set, because its window comes round again exactly then. A second collision is a new capture into one copy while another copy is presenting its result. Both are provoked by long runs of valid operations in back-to-back windows, and also by runs with random gaps and with scrambled operands in the non-capture cycles. A behavioural model in the bench queues each captured set with its due cycle. Every clock it checks the presence, timing, order and value of each pulse, and checks that the output holds steady between pulses.

// File: rtl/avg_pkg.sv
package avg_pkg;

    // Integer ceiling division used for digit and copy counts.
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Operation duration: one cycle per digit plus one for the registered
    // sum digit, raised to the next multiple of the window length.
    function automatic int op_duration(input int ndig, input int pt);
        return cdiv(ndig + 1, pt) * pt;
    endfunction

    // Phase of the window counter.
    typedef enum logic {
        PH_CAPTURE = 1'b0,
        PH_HOLD    = 1'b1
    } win_phase_e;

endpackage

// File: rtl/avg_digit_core.sv
module avg_digit_core #(
    parameter int NUM_IN = 4,
    parameter int SDW    = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr,
    input  logic                           en,
    input  logic [NUM_IN-1:0][SDW-1:0]     dig_in,
    output logic [SDW-1:0]                 dig_out,
    output logic                           dig_vld
);
    localparam int DSW = SDW + $clog2(NUM_IN) + 1;
    localparam int CW  = DSW - SDW;

    logic [CW-1:0]  carry_q;
    logic [DSW-1:0] total;

    always_comb begin
        total = DSW'(carry_q);
        for (int i = 0; i < NUM_IN; i++) begin
            total = total + DSW'(dig_in[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= '0;
            dig_out <= '0;
            dig_vld <= 1'b0;
        end else if (clr) begin
            carry_q <= '0;
            dig_vld <= 1'b0;
        end else begin
            dig_vld <= en;
            if (en) begin
                dig_out <= total[SDW-1:0];
                carry_q <= total[DSW-1:SDW];
            end
        end
    end

    // R3: the running carry never reaches the operand count
    assert_carry_bound_R3: assert property (@(posedge clk) disable iff (rst)
        32'(carry_q) < NUM_IN);

endmodule

// File: rtl/avg_lane.sv
module avg_lane #(
    parameter int DATA_W = 8,
    parameter int NUM_IN = 4,
    parameter int SDW    = 2,
    parameter int NDIG   = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              load,
    input  logic [NUM_IN-1:0][DATA_W-1:0]     ops,
    output logic [SDW-1:0]                    dig_out,
    output logic                              dig_vld
);
    localparam int SHW = NDIG * SDW;
    localparam int LW  = $clog2(NDIG + 1);

    logic [NUM_IN-1:0][SHW-1:0] sh_q;
    logic [LW-1:0]              left_q;
    logic                       feed;
    logic [NUM_IN-1:0][SDW-1:0] digits;

    assign feed = (left_q != '0);

    always_comb begin
        for (int i = 0; i < NUM_IN; i++) begin
            digits[i] = sh_q[i][SDW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            for (int i = 0; i < NUM_IN; i++) begin
                sh_q[i] <= SHW'(ops[i]);
            end
            left_q <= LW'(NDIG);
        end else if (feed) begin
            for (int i = 0; i < NUM_IN; i++) begin
                sh_q[i] <= sh_q[i] >> SDW;
            end
            left_q <= left_q - LW'(1);
        end
    end

    avg_digit_core #(
        .NUM_IN (NUM_IN),
        .SDW    (SDW)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .clr     (load),
        .en      (feed),
        .dig_in  (digits),
        .dig_out (dig_out),
        .dig_vld (dig_vld)
    );

    // R7: a copy is reloaded only after its previous operands are fully fed
    assert_load_idle_R7: assert property (@(posedge clk) disable iff (rst)
        load |-> (left_q == '0));

endmodule

// File: rtl/avg_collect.sv
module avg_collect #(
    parameter int SDW  = 2,
    parameter int NDIG = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SDW-1:0]         dig_in,
    input  logic                   dig_vld,
    output logic                   done,
    output logic [NDIG*SDW-1:0]    value
);
    localparam int SHW = NDIG * SDW;
    localparam int GW  = $clog2(NDIG + 1);

    logic [GW-1:0] got_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            got_q <= '0;
            done  <= 1'b0;
            value <= '0;
        end else begin
            done <= 1'b0;
            if (dig_vld) begin
                value <= {dig_in, value[SHW-1:SDW]};
                if (got_q == GW'(NDIG - 1)) begin
                    got_q <= '0;
                    done  <= 1'b1;
                end else begin
                    got_q <= got_q + GW'(1);
                end
            end
        end
    end

    // R4: completion is a single-cycle pulse
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/avg_tput_wrap.sv
module avg_tput_wrap #(
    parameter int DATA_W = 8,
    parameter int NUM_IN = 4,
    parameter int SDW    = 2,
    parameter int PT     = 2,
    parameter int SEL_HI = 9,
    parameter int SEL_LO = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    input  logic [NUM_IN-1:0][DATA_W-1:0]  in_ops,
    output logic                           out_valid,
    output logic [SEL_HI-SEL_LO:0]         out_avg
);
    import avg_pkg::*;

    localparam int SUM_W = DATA_W + $clog2(NUM_IN);
    localparam int NDIG  = cdiv(SUM_W, SDW);
    localparam int SHW   = NDIG * SDW;
    localparam int OD    = op_duration(NDIG, PT);
    localparam int NCOPY = OD / PT;
    localparam int SLW   = (PT > 1) ? $clog2(PT) : 1;
    localparam int RRW   = (NCOPY > 1) ? $clog2(NCOPY) : 1;

    logic [SLW-1:0]   slot_q;
    logic [RRW-1:0]   rr_q;
    win_phase_e       phase;
    logic [NCOPY-1:0] load;
    logic [NCOPY-1:0] done;
    logic [SHW-1:0]   val [NCOPY];
    logic [SHW-1:0]   picked;
    logic [SHW-1:0]   unused_pick;

    assign phase = (slot_q == '0) ? PH_CAPTURE : PH_HOLD;

    // Window counter and round-robin owner, both free running after reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            rr_q   <= '0;
        end else begin
            slot_q <= (slot_q == SLW'(PT - 1)) ? '0 : slot_q + SLW'(1);
            if (phase == PH_CAPTURE) begin
                rr_q <= (rr_q == RRW'(NCOPY - 1)) ? '0 : rr_q + RRW'(1);
            end
        end
    end

    for (genvar k = 0; k < NCOPY; k++) begin : g_copy
        logic [SDW-1:0] dig;
        logic           dvld;

        assign load[k] = (phase == PH_CAPTURE) && in_valid && (rr_q == RRW'(k));

        avg_lane #(
            .DATA_W (DATA_W),
            .NUM_IN (NUM_IN),
            .SDW    (SDW),
            .NDIG   (NDIG)
        ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .load    (load[k]),
            .ops     (in_ops),
            .dig_out (dig),
            .dig_vld (dvld)
        );

        avg_collect #(
            .SDW  (SDW),
            .NDIG (NDIG)
        ) u_collect (
            .clk     (clk),
            .rst     (rst),
            .dig_in  (dig),
            .dig_vld (dvld),
            .done    (done[k]),
            .value   (val[k])
        );
    end

    // Result selection: at most one copy completes in any cycle.
    always_comb begin
        picked = '0;
        for (int k = 0; k < NCOPY; k++) begin
            if (done[k]) begin
                picked = picked | val[k];
            end
        end
    end

    assign unused_pick = picked;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_avg   <= '0;
        end else begin
            out_valid <= |done;
            if (|done) begin
                out_avg <= picked[SEL_HI:SEL_LO];
            end
        end
    end

    // R5: copies finish in distinct cycles
    assert_single_done_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done));

    // R4: every output pulse follows a copy completion
    assert_out_follows_done_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(|done));

    // R9: output value holds between pulses
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_avg));

    // R2: window counter stays inside the window
    assert_slot_range_R2: assert property (@(posedge clk) disable iff (rst)
        32'(slot_q) < PT);

    // R8: the window owner stays inside the copy range
    assert_rr_range_R8: assert property (@(posedge clk) disable iff (rst)
        32'(rr_q) < NCOPY);

endmodule

// File: tb/tb_avg_tput_wrap.sv
module tb_avg_tput_wrap;
    localparam int PT  = 2;
    localparam int LAT = 8;   // R4: capture cycle to pulse, default parameters

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [3:0][7:0] in_ops = '0;
    logic            out_valid;
    logic [7:0]      out_avg;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit finished = 1'b0;
    string cur_req = "R3";
    int exp_val[$];
    int exp_due[$];
    int last_out = 0;

    always #5 clk = ~clk;

    avg_tput_wrap dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ops    (in_ops),
        .out_valid (out_valid),
        .out_avg   (out_avg)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Reference model: queue each capture with its due cycle.
    always @(posedge clk) begin
        if (!rst) begin
            if ((cyc % PT) == 0 && in_valid) begin
                int s;
                s = int'(in_ops[0]) + int'(in_ops[1]) + int'(in_ops[2]) + int'(in_ops[3]);
                exp_val.push_back((s >> 2) & 255);
                exp_due.push_back(cyc + LAT);
            end
            cyc <= cyc + 1;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            bit due_now;
            due_now = (exp_due.size() > 0) && (exp_due[0] == cyc);
            if (exp_due.size() > 0 && exp_due[0] < cyc) begin
                n_tests++;
                n_fail++;
                $display("FAIL R5 cycle %0d: actual missing result expected %0d", cyc, exp_val[0]);
                void'(exp_val.pop_front());
                void'(exp_due.pop_front());
            end
            check({cur_req, " R4 R6 valid"}, int'(out_valid), int'(due_now));
            if (due_now) begin
                check({cur_req, " R3 R5 value"}, int'(out_avg), exp_val[0]);
                last_out = exp_val[0];
                void'(exp_val.pop_front());
                void'(exp_due.pop_front());
            end else begin
                check("R9 hold", int'(out_avg), last_out);
            end
        end
    end

    task automatic window(input bit v, input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] c, input logic [7:0] d, input bit scramble);
        in_valid = v;
        in_ops   = {d, c, b, a};
        @(negedge clk);
        for (int i = 1; i < PT; i++) begin
            if (scramble) begin
                in_ops   = $urandom;
                in_valid = 1'($urandom % 2);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            report();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check("R1 valid", int'(out_valid), 0);
            check("R1 avg", int'(out_avg), 0);
        end
        rst = 1'b0;

        // R3: directed corner values
        cur_req = "R3";
        window(1'b1, 8'd0,   8'd0,   8'd0,   8'd0,   1'b0);
        window(1'b1, 8'd255, 8'd255, 8'd255, 8'd255, 1'b0);
        window(1'b1, 8'd1,   8'd1,   8'd1,   8'd0,   1'b0);
        window(1'b1, 8'd1,   8'd1,   8'd1,   8'd1,   1'b0);
        window(1'b1, 8'd200, 8'd3,   8'd77,  8'd129, 1'b0);
        window(1'b0, 8'd9,   8'd9,   8'd9,   8'd9,   1'b0);
        window(1'b1, 8'd128, 8'd128, 8'd127, 8'd127, 1'b0);

        // R5 R7 R8: back-to-back valid windows, copies reloaded as they finish
        cur_req = "R5 R7";
        for (int i = 0; i < 300; i++) begin
            window(1'b1, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'b0);
        end

        // R6 R8: random gaps, rotation continues through idle windows
        cur_req = "R6 R8";
        for (int i = 0; i < 300; i++) begin
            window(1'($urandom % 2), 8'($urandom), 8'($urandom), 8'($urandom),
                   8'($urandom), 1'b0);
        end

        // R2: operands and valid scrambled outside the capture cycle
        cur_req = "R2";
        for (int i = 0; i < 300; i++) begin
            window(1'($urandom % 4 != 0), 8'($urandom), 8'($urandom), 8'($urandom),
                   8'($urandom), 1'b1);
        end

        in_valid = 1'b0;
        in_ops   = '0;
        repeat (LAT + 6) @(negedge clk);
        check("R5 drained", exp_val.size(), 0);

        finished = 1'b1;
        report();
        $finish;
    end

endmodule